// File: doc/BRIEF.md
# Triggered Digital Input Capture

This block records a 32-line parallel input into a capture FIFO once an external trigger edge has been seen. The lines come in as two 16-line halves: the low half on `port_a` (word bits 15..0) and the high half on `port_b` (word bits 31..16). After software arms the block, the block waits for a trigger edge of the selected polarity. It then takes samples on one of four strobes: a fast internal rate, a slow internal rate, an external pacer tick, or an external request line. The request line can act either as a sampling clock at full core rate or as one half of a request/acknowledge handshake.

Each sample is cut to 8, 16 or 32 bits and packed into 32-bit words, with the earliest sample in the lowest lane. Complete words are pushed into the FIFO, which the consumer drains through a show-ahead pop port. A programmed length ends the capture, and a running sample count is visible. A word that reaches a full FIFO is lost and raises a sticky overflow flag. In handshake mode the acknowledge is held back while the FIFO is full, so the source waits instead of losing data.

Top module: `dicap_top`

## Requirements
- R1: The captured 32-bit word is `{port_b, port_a}`: `port_a` lands in bits 15..0 and `port_b` in bits 31..16, unchanged, when `width_sel` = 2 (32-bit samples; code 3 also means 32-bit).
- R2: After `arm` rises, no sample is taken until a trigger edge is seen on `trig_in`: rising when `trig_pol` = 1, falling when `trig_pol` = 0. An edge of the other direction starts nothing.
- R3: With `strobe_src` = 0, samples are taken every FAST_DIV (default 2) cycles. The first sample uses the inputs present FAST_DIV cycles after the cycle in which the trigger edge appears.
- R4: With `strobe_src` = 1, samples are taken every SLOW_DIV (default 4) cycles, with the first sample SLOW_DIV cycles after the trigger-edge cycle.
- R5: With `strobe_src` = 2, one sample is taken in every cycle of the capture in which `pacer_tick` is high.
- R6: With `strobe_src` = 3 and `hs_en` = 0, one sample is taken in every capture cycle in which `src_req` is high, up to one per clock.
- R7: With `strobe_src` = 3 and `hs_en` = 1, a high `src_req` yields exactly one sample, and `src_ack` goes high on the following cycle. `src_ack` stays high until `src_req` is low, and then drops on the next cycle.
- R8: In handshake mode, while the FIFO is full no sample is taken and `src_ack` is not raised. `overflow` stays low, and the pending request completes once a word is popped.
- R9: With `width_sel` = 0, `port_a[7:0]` of four successive samples fills word bytes 0, 1, 2, 3 in order, and the word is pushed after the fourth sample.
- R10: With `width_sel` = 1, `port_a` of two successive samples fills word bits 15..0 and then bits 31..16, and the word is pushed after the second sample.
- R11: A word pushed while the FIFO is full is dropped, the stored words are kept, and `overflow` is set. `overflow` stays set while `arm` is high and clears when `arm` is low.
- R12: `sample_cnt` counts the samples taken since arming. When `cap_len` is nonzero, capture stops after exactly `cap_len` samples. A `cap_len` of 0 means no limit.
- R13: `rd_valid` is high whenever the FIFO holds a word, and `rd_data` then shows the oldest word. Words leave in push order, one per cycle in which `rd_en` and `rd_valid` are both high.
- R14: After reset, `rd_valid`, `overflow`, `src_ack` and `sample_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | High enables capture; low returns to idle and clears status |
| trig_pol | input | 1 | 1 = rising trigger edge, 0 = falling |
| strobe_src | input | 2 | 0 fast rate, 1 slow rate, 2 pacer tick, 3 external request |
| hs_en | input | 1 | Handshake mode for strobe source 3 |
| width_sel | input | 2 | 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit samples |
| cap_len | input | CNT_W | Samples per capture, 0 = unlimited |
| port_a | input | 16 | Input lines, word bits 15..0 |
| port_b | input | 16 | Input lines, word bits 31..16 |
| pacer_tick | input | 1 | Sample strobe from the pacer timer |
| src_req | input | 1 | External strobe or handshake request |
| src_ack | output | 1 | Handshake acknowledge to the source |
| trig_in | input | 1 | External trigger line |
| rd_en | input | 1 | Pop the oldest FIFO word |
| rd_data | output | 32 | Oldest FIFO word |
| rd_valid | output | 1 | FIFO holds at least one word |
| overflow | output | 1 | Sticky: a word was dropped at a full FIFO |
| sample_cnt | output | CNT_W | Samples taken since arming |

## Verification
The input pattern gives every clock cycle its own value in every byte, with different content in the two halves. A sample taken one cycle early or late, or a swapped half, therefore shows up directly in the popped word. Each strobe source is tried at a distinct spacing (every cycle, every 2, every 3 and every 4 cycles) and with both trigger polarities, so a mixed-up source code or a wrong divider gives different data. Each sample width is paired with more than one source, which separates packing-order faults from timing faults. Directed runs separate a wrong-direction edge from a real trigger, a dropped word from a stalled one (free-running overflow against a throttled handshake), and one sample per request from repeated sampling while the request is held.

// File: rtl/dicap_pkg.sv
package dicap_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } cap_state_e;

  localparam logic [1:0] SRC_FAST  = 2'd0;
  localparam logic [1:0] SRC_SLOW  = 2'd1;
  localparam logic [1:0] SRC_PACER = 2'd2;
  localparam logic [1:0] SRC_EXT   = 2'd3;

  localparam logic [1:0] WSEL_8  = 2'd0;
  localparam logic [1:0] WSEL_16 = 2'd1;

  // Index of the lane that completes a word for a given sample width.
  function automatic logic [1:0] last_lane(input logic [1:0] wsel);
    case (wsel)
      WSEL_8:  return 2'd3;
      WSEL_16: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  // Places one sample into lane 'lane' of the partial word.
  function automatic logic [WORD_W-1:0] place_sample(input logic [WORD_W-1:0] acc,
                                                     input logic [WORD_W-1:0] smp,
                                                     input logic [1:0]        wsel,
                                                     input logic [1:0]        lane);
    logic [WORD_W-1:0] r;
    r = acc;
    case (wsel)
      WSEL_8:  r[{lane, 3'b000} +: 8]     = smp[7:0];
      WSEL_16: r[{lane[0], 4'b0000} +: 16] = smp[15:0];
      default: r = smp;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dicap_strobe.sv
module dicap_strobe
  import dicap_pkg::*;
#(
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] src,
  input  logic       hs_en,
  input  logic       pacer_tick,
  input  logic       ext_req,
  input  logic       fifo_full,
  output logic       take,
  output logic       ack
);
  localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int DW      = $clog2(MAX_DIV) + 1;

  logic [DW-1:0] div_cnt;
  logic [DW-1:0] div_lim;
  logic          hs_mode;
  logic          hs_ok;

  assign div_lim = (src == SRC_SLOW) ? DW'(SLOW_DIV - 1) : DW'(FAST_DIV - 1);
  assign hs_mode = hs_en && (src == SRC_EXT);
  assign hs_ok   = ext_req && !ack && !fifo_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          div_cnt <= '0;
    else if (!run || div_cnt == div_lim) div_cnt <= '0;
    else                                 div_cnt <= div_cnt + 1'b1;
  end

  always_comb begin
    case (src)
      SRC_PACER: take = run && pacer_tick;
      SRC_EXT:   take = run && (hs_en ? hs_ok : ext_req);
      default:   take = run && (div_cnt == div_lim);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ack <= 1'b0;
    else if (!hs_mode || !ext_req) ack <= 1'b0;
    else if (take)                 ack <= 1'b1;
  end

endmodule

// File: rtl/dicap_packer.sv
module dicap_packer
  import dicap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic [1:0]        wsel,
  input  logic [WORD_W-1:0] sample,
  output logic              push,
  output logic [WORD_W-1:0] word
);
  logic [1:0]        lane;
  logic [WORD_W-1:0] acc;

  assign word = place_sample(acc, sample, wsel, lane);
  assign push = take && (lane == last_lane(wsel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane <= '0;
      acc  <= '0;
    end else if (clear) begin
      lane <= '0;
      acc  <= '0;
    end else if (take) begin
      if (push) begin
        lane <= '0;
        acc  <= '0;
      end else begin
        lane <= lane + 1'b1;
        acc  <= word;
      end
    end
  end

endmodule

// File: rtl/dicap_fifo.sv
module dicap_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          full,
  output logic          drop
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_wr, do_rd;

  assign rd_valid = (count != '0);
  assign full     = (count == (AW+1)'(DEPTH));
  assign do_rd    = rd_en && rd_valid;
  assign do_wr    = wr_en && (!full || do_rd);
  assign drop     = wr_en && !do_wr;
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/dicap_top.sv
module dicap_top
  import dicap_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int FAST_DIV   = 2,
  parameter int SLOW_DIV   = 4,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              trig_pol,
  input  logic [1:0]        strobe_src,
  input  logic              hs_en,
  input  logic [1:0]        width_sel,
  input  logic [CNT_W-1:0]  cap_len,
  input  logic [15:0]       port_a,
  input  logic [15:0]       port_b,
  input  logic              pacer_tick,
  input  logic              src_req,
  output logic              src_ack,
  input  logic              trig_in,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              overflow,
  output logic [CNT_W-1:0]  sample_cnt
);
  cap_state_e        st;
  logic              trig_q;
  logic              trig_edge;
  logic              in_run, in_wait, in_idle;
  logic              take;
  logic              last_take;
  logic              pk_push;
  logic [WORD_W-1:0] pk_word;
  logic              fifo_full;
  logic              fifo_drop;

  assign in_run    = (st == ST_RUN);
  assign in_wait   = (st == ST_WAIT);
  assign in_idle   = (st == ST_IDLE);
  assign trig_edge = trig_pol ? (trig_in && !trig_q) : (!trig_in && trig_q);
  assign last_take = take && (cap_len != '0) && (sample_cnt == cap_len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st <= ST_IDLE;
    else if (!arm) st <= ST_IDLE;
    else begin
      case (st)
        ST_IDLE: st <= ST_WAIT;
        ST_WAIT: if (trig_edge) st <= ST_RUN;
        ST_RUN:  if (last_take) st <= ST_DONE;
        default: st <= st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sample_cnt <= '0;
    else if (in_idle) sample_cnt <= '0;
    else if (take)    sample_cnt <= sample_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         overflow <= 1'b0;
    else if (!arm)      overflow <= 1'b0;
    else if (fifo_drop) overflow <= 1'b1;
  end

  dicap_strobe #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_strobe (
    .clk(clk), .rst_n(rst_n), .run(in_run), .src(strobe_src), .hs_en(hs_en),
    .pacer_tick(pacer_tick), .ext_req(src_req), .fifo_full(fifo_full),
    .take(take), .ack(src_ack)
  );

  dicap_packer u_packer (
    .clk(clk), .rst_n(rst_n), .clear(in_idle), .take(take), .wsel(width_sel),
    .sample({port_b, port_a}), .push(pk_push), .word(pk_word)
  );

  dicap_fifo #(.DEPTH(FIFO_DEPTH), .DW(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(pk_push), .wr_data(pk_word),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .full(fifo_full), .drop(fifo_drop)
  );

endmodule

// File: rtl/dicap_checker.sv
module dicap_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic             hs_en,
  input logic [1:0]       strobe_src,
  input logic [CNT_W-1:0] cap_len,
  input logic             rd_en,
  input logic             rd_valid,
  input logic             src_req,
  input logic             src_ack,
  input logic             overflow,
  input logic [CNT_W-1:0] sample_cnt,
  input logic             fifo_full,
  input logic             fifo_drop,
  input logic             in_run,
  input logic             in_wait
);
  AST_WAIT_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |=> (sample_cnt == '0)); // R2
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && cap_len != '0) |-> (sample_cnt < cap_len)); // R12
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && arm) |=> overflow); // R11
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_drop && arm) |=> overflow); // R11
  AST_HS_THROTTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en && strobe_src == 2'd3 && fifo_full) |=> !$rose(src_ack)); // R8
  AST_HS_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en && strobe_src == 2'd3) |-> !fifo_drop); // R8
  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_ack) |-> $past(src_req)); // R7
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ack && !src_req) |=> !src_ack); // R7
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_en) |=> rd_valid); // R13
endmodule

bind dicap_top dicap_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .hs_en(hs_en), .strobe_src(strobe_src),
  .cap_len(cap_len), .rd_en(rd_en), .rd_valid(rd_valid), .src_req(src_req),
  .src_ack(src_ack), .overflow(overflow), .sample_cnt(sample_cnt),
  .fifo_full(fifo_full), .fifo_drop(fifo_drop), .in_run(in_run), .in_wait(in_wait)
);

// File: tb/tb_dicap_top.sv
module tb_dicap_top;
  localparam int CNT_W = 16;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, trig_pol = 1'b1, hs_en = 1'b0, pacer_tick = 1'b0;
  logic src_req = 1'b0, trig_in = 1'b0, rd_en = 1'b0;
  logic [1:0] strobe_src = 2'd0, width_sel = 2'd2;
  logic [CNT_W-1:0] cap_len = '0;
  logic [15:0] port_a = '0, port_b = '0;
  logic src_ack, rd_valid, overflow;
  logic [31:0] rd_data;
  logic [CNT_W-1:0] sample_cnt;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  dicap_top #(.FIFO_DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trig_pol(trig_pol), .strobe_src(strobe_src),
    .hs_en(hs_en), .width_sel(width_sel), .cap_len(cap_len), .port_a(port_a),
    .port_b(port_b), .pacer_tick(pacer_tick), .src_req(src_req), .src_ack(src_ack),
    .trig_in(trig_in), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .overflow(overflow), .sample_cnt(sample_cnt)
  );

  typedef struct packed {
    logic [1:0] src;
    logic [1:0] wsel;
    logic       pol;
    logic [7:0] len;
    logic [3:0] k;   // cycles between samples under this vector's stimulus
  } vec_t;

  // R3 R4 R5 R6 R9 R10 R1: source x width x polarity grid
  localparam vec_t VECS [7] = '{
    '{2'd0, 2'd2, 1'b1, 8'd4, 4'd2},
    '{2'd1, 2'd2, 1'b0, 8'd3, 4'd4},
    '{2'd2, 2'd1, 1'b1, 8'd4, 4'd3},
    '{2'd3, 2'd0, 1'b1, 8'd8, 4'd1},
    '{2'd0, 2'd0, 1'b0, 8'd4, 4'd2},
    '{2'd3, 2'd1, 1'b0, 8'd6, 4'd1},
    '{2'd1, 2'd0, 1'b1, 8'd4, 4'd4}
  };

  function automatic logic [31:0] pat(input int m);
    logic [7:0] b;
    b = m[7:0];
    return {b ^ 8'hC3, b + 8'h11, ~b, b};
  endfunction

  function automatic logic [31:0] exp_word(input vec_t v, input int w);
    logic [31:0] s0, s1, s2, s3;
    int k;
    k = int'(v.k);
    if (v.wsel == 2'd0) begin
      s0 = pat((4*w+1)*k); s1 = pat((4*w+2)*k); s2 = pat((4*w+3)*k); s3 = pat((4*w+4)*k);
      return {s3[7:0], s2[7:0], s1[7:0], s0[7:0]};
    end else if (v.wsel == 2'd1) begin
      s0 = pat((2*w+1)*k); s1 = pat((2*w+2)*k);
      return {s1[15:0], s0[15:0]};
    end
    return pat((w+1)*k);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive_din(input logic [31:0] d);
    port_a = d[15:0];
    port_b = d[31:16];
  endtask

  task automatic pop_expect(input logic [31:0] exp, input string req);
    check(rd_valid === 1'b1, req, {31'd0, rd_valid}, 32'd1);
    check(rd_data === exp, req, rd_data, exp);
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
  endtask

  // Arms with trigger held inactive; returns with the edge driven in the current cycle.
  task automatic arm_and_trigger(input logic pol);
    trig_pol = pol;
    trig_in  = ~pol;
    arm = 1'b0;
    tick(); tick();
    arm = 1'b1;
    tick(); tick(); tick();
    trig_in = pol;
  endtask

  task automatic run_vec(input vec_t v);
    int per, nw, last_m;
    strobe_src = v.src; width_sel = v.wsel; cap_len = CNT_W'(v.len); hs_en = 1'b0;
    pacer_tick = 1'b0; src_req = 1'b0;
    drive_din(pat(0));
    arm_and_trigger(v.pol);
    last_m = int'(v.k) * int'(v.len) + 6;
    for (int m = 1; m <= last_m; m++) begin
      tick();
      drive_din(pat(m));
      pacer_tick = (m % 3 == 0);
      src_req = 1'b1;
      if (m == 4) trig_in = ~v.pol;
    end
    tick();
    src_req = 1'b0; pacer_tick = 1'b0;
    check(sample_cnt === CNT_W'(v.len), "R12 length stop", 32'(sample_cnt), 32'(v.len));
    per = (v.wsel == 2'd0) ? 4 : (v.wsel == 2'd1) ? 2 : 1;
    nw = int'(v.len) / per;
    for (int w = 0; w < nw; w++)
      pop_expect(exp_word(v, w), "R3/R4/R5/R6 with R1/R9/R10 packed data");
    check(rd_valid === 1'b0, "R13 drained", {31'd0, rd_valid}, 32'd0);
    arm = 1'b0;
    tick();
  endtask

  task automatic hs_xfer(input logic [31:0] val, output bit got);
    got = 1'b0;
    drive_din(val);
    src_req = 1'b1;
    for (int k = 0; k < 8; k++) begin
      tick();
      if (src_ack) begin
        got = 1'b1;
        break;
      end
    end
    src_req = 1'b0;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R14: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit got;
    logic [CNT_W-1:0] cnt_before;
    int pops;
    repeat (3) @(posedge clk);
    #1;
    // R14 reset state
    check(rd_valid === 1'b0, "R14 rd_valid", {31'd0, rd_valid}, 32'd0);
    check(overflow === 1'b0, "R14 overflow", {31'd0, overflow}, 32'd0);
    check(src_ack === 1'b0, "R14 src_ack", {31'd0, src_ack}, 32'd0);
    check(sample_cnt === '0, "R14 sample_cnt", 32'(sample_cnt), 32'd0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < 7; i++) run_vec(VECS[i]);

    // R2: wrong-direction edge does not start capture
    strobe_src = 2'd3; width_sel = 2'd2; cap_len = CNT_W'(4); hs_en = 1'b0;
    arm_and_trigger(1'b0);     // trig_in now low (falling), but set polarity to rising
    trig_pol = 1'b1;
    src_req = 1'b1;
    repeat (10) tick();
    check(sample_cnt === '0, "R2 wrong edge count", 32'(sample_cnt), 32'd0);
    check(rd_valid === 1'b0, "R2 wrong edge fifo", {31'd0, rd_valid}, 32'd0);
    src_req = 1'b0; arm = 1'b0;
    tick();

    // R11 overflow: free-running external clock into a full FIFO
    strobe_src = 2'd3; width_sel = 2'd2; cap_len = '0; hs_en = 1'b0;
    drive_din(pat(0));
    arm_and_trigger(1'b1);
    for (int m = 1; m <= 70; m++) begin
      tick();
      drive_din(pat(m));
      src_req = 1'b1;
    end
    tick();
    src_req = 1'b0;
    check(overflow === 1'b1, "R11 overflow set", {31'd0, overflow}, 32'd1);
    check(rd_data === pat(1), "R11 oldest kept", rd_data, pat(1));
    pops = 0;
    for (int j = 0; j < DEPTH + 8; j++) begin
      if (rd_valid) begin
        if (pops == DEPTH - 1)
          check(rd_data === pat(DEPTH), "R11 last stored word", rd_data, pat(DEPTH));
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        pops++;
      end
    end
    check(pops == DEPTH, "R11 words stored", 32'(pops), 32'(DEPTH));
    check(overflow === 1'b1, "R11 sticky while armed", {31'd0, overflow}, 32'd1);
    arm = 1'b0;
    tick();
    check(overflow === 1'b0, "R11 cleared by disarm", {31'd0, overflow}, 32'd0);

    // R7 handshake: one sample per request, ack follows
    strobe_src = 2'd3; width_sel = 2'd2; cap_len = '0; hs_en = 1'b1;
    arm_and_trigger(1'b1);
    tick();
    for (int j = 0; j < 3; j++) begin
      drive_din(pat(100 + j));
      src_req = 1'b1;
      tick();
      check(src_ack === 1'b1, "R7 ack after req", {31'd0, src_ack}, 32'd1);
      tick(); tick();
      check(sample_cnt === CNT_W'(j + 1), "R7 one sample per req", 32'(sample_cnt), 32'(j + 1));
      src_req = 1'b0;
      tick();
      check(src_ack === 1'b0, "R7 ack release", {31'd0, src_ack}, 32'd0);
    end
    for (int j = 0; j < 3; j++) pop_expect(pat(100 + j), "R7 handshake data");

    // R8 throttle: fill the FIFO by handshake, then a request must wait
    for (int j = 0; j < DEPTH; j++) begin
      hs_xfer(pat(j + 7), got);
      if (!got) check(1'b0, "R8 fill handshake", 32'(j), 32'(DEPTH));
    end
    cnt_before = sample_cnt;
    drive_din(32'hDEAD_BEEF);
    src_req = 1'b1;
    repeat (5) tick();
    check(src_ack === 1'b0, "R8 ack withheld", {31'd0, src_ack}, 32'd0);
    check(overflow === 1'b0, "R8 no overflow", {31'd0, overflow}, 32'd0);
    check(sample_cnt === cnt_before, "R8 no sample when full", 32'(sample_cnt), 32'(cnt_before));
    pop_expect(pat(7), "R8 oldest word");
    tick();
    check(src_ack === 1'b1, "R8 ack after space", {31'd0, src_ack}, 32'd1);
    src_req = 1'b0;
    tick();
    for (int j = 1; j < DEPTH; j++) begin
      rd_en = 1'b1; tick(); rd_en = 1'b0;
    end
    check(rd_data === 32'hDEAD_BEEF, "R8 held sample delivered", rd_data, 32'hDEAD_BEEF);
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    check(rd_valid === 1'b0, "R13 empty after drain", {31'd0, rd_valid}, 32'd0);
    arm = 1'b0; hs_en = 1'b0;
    tick();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule